// File: doc/BRIEF.md
# Dual-Channel Interrupt Thinning Counter

This block lowers the rate of two periodic interrupt sources. Each source delivers single-cycle event pulses. A channel that is counting passes on only one event in every N, where N is that channel's 3-bit skip setting. The event that brings the channel's counter up to N is forwarded as a gated interrupt pulse in the same cycle, and the counter then returns to zero. All other events are held back.

A channel stops thinning when its enable is low, when its skip setting is zero, or while the global hold-mode input is high. In any of these states the counter is forced to zero and every source event goes straight through to the output.

Both counters can be observed through one 8-bit read-back byte. The counters are not cleared when the source timers stop. Only the listed clear conditions and reset return them to zero. The two channels share nothing except the hold-mode input and the read-back byte.

Top module: `irq_thin_top`

## Requirements
- R1: While a channel is counting (enable 1, skip setting non-zero, hold-mode 0), each event on that channel raises its counter by one at the next clock edge, unless R4 applies.
- R2: A channel whose enable input is 0 has a counter of 0 after the next clock edge.
- R3: A channel whose skip setting is 000 has a counter of 0 after the next clock edge.
- R4: When an event makes a counting channel's counter equal its skip setting, the channel's interrupt output is 1 in that same cycle and the counter is 0 after the edge. While counting, every other event gives interrupt output 0.
- R5: While hold-mode is 1, both counters are 0 after each clock edge.
- R6: The read-back byte carries channel A's counter in bits 6:4 and channel B's counter in bits 2:0. Bits 7 and 3 are always 0.
- R7: When any clear condition holds for a channel (enable 0, skip setting 000 or hold-mode 1), that channel's interrupt output equals its event input in the same cycle.
- R8: If a clear condition and an event arrive in the same cycle, the clear wins. The counter is 0 after the edge and the event is passed through as in R7.
- R9: An event on one channel never changes the other channel's counter.
- R10: After reset both counters read 0.
- R11: A counting channel with no event keeps its counter unchanged, however long the sources stay idle.
- R12: If a counting channel's counter equals its skip setting without an event (because the setting was lowered), the counter is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_mode | input | 1 | Global mode that holds both counters at zero |
| a_en | input | 1 | Channel A counting enable |
| a_skip | input | 3 | Channel A skip setting N |
| a_evt | input | 1 | Channel A source event pulse |
| b_en | input | 1 | Channel B counting enable |
| b_skip | input | 3 | Channel B skip setting N |
| b_evt | input | 1 | Channel B source event pulse |
| a_irq | output | 1 | Channel A gated interrupt pulse |
| b_irq | output | 1 | Channel B gated interrupt pulse |
| cnt_rd | output | 8 | Read-back byte of both counters |

## Verification
The hardest case to reach from the ports is a clear condition that arrives in the same cycle as an event. A second hard case is a counter sitting exactly on a skip setting that has just been lowered to meet it. The stimulus reaches both by first building a known count with events while the channel is counting. It then changes the control inputs just after a clock edge, so that the next event pulse and the new control value meet the same edge. Each case is then judged both on the interrupt output in that cycle and on the count read back after the edge.

// File: rtl/irq_thin_pkg.sv
package irq_thin_pkg;
  parameter int THIN_CNT_W = 3;
  parameter int THIN_NCH   = 2;

  typedef logic [THIN_CNT_W-1:0] thin_cnt_t;

  // Counter value after one accepted event.
  function automatic thin_cnt_t thin_step(input thin_cnt_t cur);
    return cur + thin_cnt_t'(1);
  endfunction

  // True when the next event completes a group of skip events.
  function automatic logic thin_hits(input thin_cnt_t cur, input thin_cnt_t skip);
    return thin_step(cur) == skip;
  endfunction

  // True when any clear condition applies to a channel.
  function automatic logic thin_bypass(input logic hold, input logic en,
                                       input thin_cnt_t skip);
    return hold | ~en | (skip == '0);
  endfunction
endpackage

// File: rtl/irq_thin_chan.sv
module irq_thin_chan
  import irq_thin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      en,
  input  thin_cnt_t skip,
  input  logic      evt,
  output logic      irq,
  output thin_cnt_t cnt
);
  thin_cnt_t cnt_q;
  logic      clr_w;    // any clear condition
  logic      match_w;  // counter sits on the skip value with no event needed
  logic      fire_w;   // event completes a group

  assign clr_w   = thin_bypass(hold, en, skip);
  assign match_w = ~clr_w & (cnt_q == skip);
  assign fire_w  = ~clr_w & ~match_w & evt & thin_hits(cnt_q, skip);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_w)   cnt_q <= '0;
    else if (match_w) cnt_q <= '0;
    else if (evt)     cnt_q <= fire_w ? '0 : thin_step(cnt_q);
  end

  always_comb begin
    if (clr_w) irq = evt;
    else       irq = fire_w;
  end

  assign cnt = cnt_q;

  assert_clear_on_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);
  assert_clear_on_zero_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (skip == '0) |=> cnt_q == '0);
  assert_hold_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt_q == '0);
  assert_wrap_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_w) |=> cnt_q == '0);
  assert_irq_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt);
  assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !match_w && evt && !irq) |=> cnt_q == thin_cnt_t'($past(cnt_q) + 1'b1));
  assert_idle_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !match_w && !evt) |=> $stable(cnt_q));
  assert_match_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> cnt_q == '0);
endmodule

// File: rtl/irq_thin_pack.sv
module irq_thin_pack
  import irq_thin_pkg::*;
#(
  parameter int NCH   = THIN_NCH,
  parameter int CNT_W = THIN_CNT_W,
  localparam int FIELD_W = CNT_W + 1,
  localparam int RD_W    = NCH * FIELD_W
) (
  input  logic [NCH*CNT_W-1:0] cnt_flat,   // channel 0 in the lowest slice
  output logic [RD_W-1:0]      rd
);
  // Channel 0 (A) takes the top field, the last channel the bottom field.
  for (genvar i = 0; i < NCH; i++) begin : g_field
    assign rd[(NCH-1-i)*FIELD_W +: FIELD_W] = {1'b0, cnt_flat[i*CNT_W +: CNT_W]};
  end
endmodule

// File: rtl/irq_thin_top.sv
module irq_thin_top
  import irq_thin_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_mode,
  input  logic                  a_en,
  input  logic [THIN_CNT_W-1:0] a_skip,
  input  logic                  a_evt,
  input  logic                  b_en,
  input  logic [THIN_CNT_W-1:0] b_skip,
  input  logic                  b_evt,
  output logic                  a_irq,
  output logic                  b_irq,
  output logic [THIN_NCH*(THIN_CNT_W+1)-1:0] cnt_rd
);
  localparam int NCH   = THIN_NCH;
  localparam int CNT_W = THIN_CNT_W;

  logic [NCH-1:0]       en_v, evt_v, irq_v;
  thin_cnt_t            skip_v [NCH];
  logic [NCH*CNT_W-1:0] cnt_flat;

  assign en_v   = {b_en, a_en};
  assign evt_v  = {b_evt, a_evt};
  assign skip_v[0] = a_skip;
  assign skip_v[1] = b_skip;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    thin_cnt_t cnt_w;
    irq_thin_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold_mode),
      .en   (en_v[c]),
      .skip (skip_v[c]),
      .evt  (evt_v[c]),
      .irq  (irq_v[c]),
      .cnt  (cnt_w)
    );
    assign cnt_flat[c*CNT_W +: CNT_W] = cnt_w;
  end

  irq_thin_pack #(.NCH(NCH), .CNT_W(CNT_W)) u_pack (
    .cnt_flat(cnt_flat),
    .rd      (cnt_rd)
  );

  assign a_irq = irq_v[0];
  assign b_irq = irq_v[1];

  assert_hold_zero_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_mode |=> cnt_rd == '0);
  assert_b_event_keeps_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_evt && !a_evt && a_en && !hold_mode && a_skip != '0
     && $stable(a_skip) && cnt_rd[6:4] != a_skip) |=> $stable(cnt_rd[6:4]));
endmodule

// File: tb/irq_thin_top_test.sv
module irq_thin_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_mode = 1'b0;
  logic       a_en = 1'b0, b_en = 1'b0;
  logic [2:0] a_skip = 3'd0, b_skip = 3'd0;
  logic       a_evt = 1'b0, b_evt = 1'b0;
  logic       a_irq, b_irq;
  logic [7:0] cnt_rd;
  logic       ia, ib;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_thin_top uut (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
    .a_en(a_en), .a_skip(a_skip), .a_evt(a_evt),
    .b_en(b_en), .b_skip(b_skip), .b_evt(b_evt),
    .a_irq(a_irq), .b_irq(b_irq), .cnt_rd(cnt_rd)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // One cycle: events at negedge, irq sampled mid-cycle, count after the edge.
  task automatic tick(input logic ea, input logic eb);
    @(negedge clk);
    a_evt = ea; b_evt = eb;
    #1; ia = a_irq; ib = b_irq;
    @(posedge clk); #1;
    a_evt = 1'b0; b_evt = 1'b0;
  endtask

  task automatic clean();
    a_en = 0; b_en = 0; a_skip = 0; b_skip = 0; hold_mode = 0;
    tick(0, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset readback", cnt_rd, 0);
  endtask

  task automatic t_count_wrap();
    a_en = 1; a_skip = 3'd5;
    for (int k = 1; k <= 4; k++) begin
      tick(1, 0);
      chk("R4 suppressed irq", ia, 0);
      chk("R1 count up", cnt_rd[6:4], k);
    end
    tick(1, 0);
    chk("R4 pulse on fifth", ia, 1);
    chk("R4 wrap to zero", cnt_rd[6:4], 0);
    tick(1, 0);
    chk("R1 restart", cnt_rd[6:4], 1);
    clean();
  endtask

  task automatic t_skip_one();
    a_en = 1; a_skip = 3'd1;
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      chk("R4 skip one passes all", ia, 1);
      chk("R4 skip one stays zero", cnt_rd[6:4], 0);
    end
    clean();
  endtask

  task automatic t_retain_disable();
    a_en = 1; a_skip = 3'd6;
    for (int k = 0; k < 3; k++) tick(1, 0);
    for (int k = 0; k < 5; k++) tick(0, 0);
    chk("R11 idle keeps count", cnt_rd[6:4], 3);
    a_en = 0;
    tick(1, 0);
    chk("R7 disabled passthrough", ia, 1);
    chk("R2 disable clears", cnt_rd[6:4], 0);
    clean();
  endtask

  task automatic t_skip_zero();
    a_en = 1; a_skip = 3'd7;
    tick(1, 0); tick(1, 0);
    chk("R1 two events", cnt_rd[6:4], 2);
    a_skip = 3'd0;
    tick(1, 0);
    chk("R7 zero skip passthrough", ia, 1);
    chk("R3 zero skip clears", cnt_rd[6:4], 0);
    clean();
  endtask

  task automatic t_hold();
    a_en = 1; b_en = 1; a_skip = 3'd7; b_skip = 3'd7;
    tick(1, 1); tick(1, 1);
    chk("R6 both counts", cnt_rd, 8'h22);
    hold_mode = 1;
    tick(1, 1);
    chk("R7 hold passthrough A", ia, 1);
    chk("R7 hold passthrough B", ib, 1);
    chk("R5 hold clears", cnt_rd, 0);
    hold_mode = 0;
    tick(1, 1);
    chk("R5 counting after hold", cnt_rd, 8'h11);
    clean();
  endtask

  task automatic t_priority();
    a_en = 1; a_skip = 3'd4;
    tick(1, 0); tick(1, 0);
    a_en = 0;
    tick(1, 0);
    chk("R8 event with clear passes", ia, 1);
    chk("R8 clear wins", cnt_rd[6:4], 0);
    clean();
  endtask

  task automatic t_indep();
    a_en = 1; b_en = 1; a_skip = 3'd7; b_skip = 3'd7;
    for (int k = 0; k < 3; k++) tick(1, 0);
    chk("R9 B untouched by A", cnt_rd[2:0], 0);
    tick(0, 1); tick(0, 1);
    chk("R9 A untouched by B", cnt_rd[6:4], 3);
    chk("R6 field layout", cnt_rd, 8'h32);
    chk("R6 pad bits zero", {cnt_rd[7], cnt_rd[3]}, 0);
    clean();
  endtask

  task automatic t_lower();
    a_en = 1; a_skip = 3'd7;
    for (int k = 0; k < 4; k++) tick(1, 0);
    chk("R1 four events", cnt_rd[6:4], 4);
    a_skip = 3'd4;
    tick(0, 0);
    chk("R12 no pulse on match", ia, 0);
    chk("R12 lowered skip clears", cnt_rd[6:4], 0);
    clean();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_count_wrap();
    t_skip_one();
    t_retain_disable();
    t_skip_zero();
    t_hold();
    t_priority();
    t_indep();
    t_lower();
    finish_run();
  end
endmodule